// File: doc/BRIEF.md
# Residue-Domain Minimum-SAD Block Matcher

This unit scores candidate blocks for motion estimation. Each valid cycle it receives one row of 16 current-block pixels and one row of 16 candidate-block pixels, all 8 bits wide, together with the candidate's displacement (u, v). Every pixel is mapped into four residue channels with moduli 15, 17, 31 and 33. The absolute pixel difference is formed inside those channels, and the 16 differences of a row are added by per-channel modulo adder trees. The row sums are then accumulated over the 16 rows of a candidate. At no point is a binary SAD built.

Comparisons are made by parity. The current pixels' LSBs, the candidate pixels' LSBs and the parity of their residue difference decide the sign of each pixel difference. The same rule, using the full-range parity of the new SAD, the stored parity of the running minimum and the parity of their difference, decides whether the finished candidate becomes the new best. The running minimum is held as residues plus an even flag.

A search controller marks the first row of each candidate, and marks the first candidate of a new current block. The unit reports the best SAD residues and the best vector through a one-cycle completion pulse.

Top module: `rns_sad_min`

## Requirements
- R1: While reset is asserted and after it is released, done is 0, best_res holds the residues of M-1 = 86954 (14, 16, 30, 32), best_even is 1 and best_u, best_v are 0.
- R2: done is a one-cycle pulse that rises at the fourth rising clock edge after the edge that samples the 16th valid row of a candidate. Idle cycles (row_vld low) between rows are allowed. done is never high at any other time.
- R3: The candidate SAD is the sum of |cur - cand| over all 256 pixel pairs. When a candidate is recorded as best, best_res holds SAD mod 15 in bits [5:0], SAD mod 17 in bits [11:6], SAD mod 31 in bits [17:12] and SAD mod 33 in bits [23:18].
- R4: The sign of each pixel difference is resolved correctly whether the candidate pixel is darker than, brighter than or equal to the current pixel. This includes the extremes SAD = 0 and SAD = 65280.
- R5: A finished candidate replaces the held minimum only when its SAD is strictly smaller. When the SAD is equal, the earlier vector is kept.
- R6: A candidate whose first row carries blk_first = 1 is compared against M-1 instead of the held minimum, so it always becomes the new best.
- R7: best_even is 1 exactly when the held minimum SAD is even.
- R8: best_res, best_even, best_u and best_v change only at the edge that raises done, or through reset.
- R9: Each best_res channel is below its modulus.
- R10: The reported vector is the cand_u, cand_v value presented with the candidate's first row. Values on later rows are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_vld | input | 1 | A row of pixels is present this cycle |
| row_first | input | 1 | This row is the first row of a candidate |
| blk_first | input | 1 | With row_first: this candidate starts a new current block |
| cur_row | input | 128 | 16 current pixels, pixel c in bits [8c+7:8c] |
| cand_row | input | 128 | 16 candidate pixels, same layout |
| cand_u | input | 6 | Candidate horizontal displacement |
| cand_v | input | 6 | Candidate vertical displacement |
| done | output | 1 | Candidate finished; best outputs updated |
| best_res | output | 24 | Residues of the best SAD (layout in R3) |
| best_even | output | 1 | Best SAD is even |
| best_u | output | 6 | Horizontal displacement of the best candidate |
| best_v | output | 6 | Vertical displacement of the best candidate |

## Verification
The bench targets candidates where every candidate pixel is brighter than the current pixel. There the forward residue difference wraps to M minus the distance, so a wrong parity select inflates the SAD far past 65280. Equal-SAD candidates at 0, 512 and 65280 expose a comparator that takes ties, because the reported vector moves to the later candidate. Block restarts after a small minimum, and a reset in the middle of a search, show whether the M-1 starting value is restored; otherwise a larger SAD is wrongly rejected. Gapped rows and vectors that change after the first row catch a row counter or a vector latch that follows the wrong cycle.

// File: rtl/rns_sad_pkg.sv
package rns_sad_pkg;

  // base exponent of the conjugate pairs; pixel width is twice this
  localparam int RN  = 4;
  localparam int PW  = 2 * RN;
  localparam int RW  = RN + 2;
  localparam int NCH = 4;

  typedef logic [RW-1:0]  ch_t;
  typedef ch_t [NCH-1:0]  rns_t;

  // channel moduli: 2^RN-1, 2^RN+1, 2^(RN+1)-1, 2^(RN+1)+1
  function automatic int modv(input int k);
    case (k)
      0:       return (1 << RN) - 1;
      1:       return (1 << RN) + 1;
      2:       return (1 << (RN + 1)) - 1;
      default: return (1 << (RN + 1)) + 1;
    endcase
  endfunction

  function automatic ch_t madd(input ch_t a, input ch_t b, input int m);
    int s;
    s = int'(a) + int'(b);
    if (s >= m) s -= m;
    return ch_t'(s);
  endfunction

  function automatic ch_t msub(input ch_t a, input ch_t b, input int m);
    int s;
    s = int'(a) - int'(b);
    if (s < 0) s += m;
    return ch_t'(s);
  endfunction

  function automatic rns_t rns_add(input rns_t a, input rns_t b);
    rns_t r;
    for (int k = 0; k < NCH; k++) r[k] = madd(a[k], b[k], modv(k));
    return r;
  endfunction

  function automatic rns_t rns_sub(input rns_t a, input rns_t b);
    rns_t r;
    for (int k = 0; k < NCH; k++) r[k] = msub(a[k], b[k], modv(k));
    return r;
  endfunction

  // residues of M-1: every channel at its modulus minus one
  function automatic rns_t rns_top();
    rns_t r;
    for (int k = 0; k < NCH; k++) r[k] = ch_t'(modv(k) - 1);
    return r;
  endfunction

  // pixel below 2^(2RN): each channel is a single folding add or subtract
  function automatic rns_t to_rns(input logic [PW-1:0] px);
    rns_t r;
    int lo1, hi1, lo2, hi2, a;
    lo1 = int'(px[RN-1:0]);
    hi1 = int'(px[PW-1:RN]);
    lo2 = int'(px[RN:0]);
    hi2 = int'(px[PW-1:RN+1]);
    a = lo1 + hi1;
    if (a >= modv(0)) a -= modv(0);
    if (a >= modv(0)) a -= modv(0);
    r[0] = ch_t'(a);
    a = lo1 - hi1;
    if (a < 0) a += modv(1);
    r[1] = ch_t'(a);
    a = lo2 + hi2;
    if (a >= modv(2)) a -= modv(2);
    r[2] = ch_t'(a);
    a = lo2 - hi2;
    if (a < 0) a += modv(3);
    r[3] = ch_t'(a);
    return r;
  endfunction

  // multiply by 2^(k-1) modulo 2^k-1: rotate a k-bit word right by one
  function automatic int rot1(input int d, input int k);
    return (d >> 1) | ((d & 1) << (k - 1));
  endfunction

  // merge a conjugate pair (mod 2^k-1, mod 2^k+1) into a value mod 4^k-1
  function automatic int pair_merge(input ch_t lo_m, input ch_t hi_p, input int k);
    int hm, d;
    hm = int'(hi_p);
    if (hm >= (1 << k) - 1) hm -= (1 << k) - 1;
    d = int'(lo_m) - hm;
    if (d < 0) d += (1 << k) - 1;
    return int'(hi_p) + ((1 << k) + 1) * rot1(d, k);
  endfunction

  // reduce a value below 2^(4RN) modulo 2^(2RN)-1 by end-around folding
  function automatic int fold_low(input int x);
    int s, msk;
    msk = (1 << PW) - 1;
    s = (x & msk) + (x >> PW);
    s = (s & msk) + (s >> PW);
    if (s == msk) s = 0;
    return s;
  endfunction

  // even flag over the whole dynamic range
  function automatic logic even_full(input rns_t r);
    int x1, x2, d;
    x1 = pair_merge(r[0], r[1], RN);
    x2 = pair_merge(r[2], r[3], RN + 1);
    d  = x1 - fold_low(x2);
    if (d < 0) d += (1 << PW) - 1;
    return ((x2 ^ d) & 1) == 0;
  endfunction

  // even flag for values within 2^(2RN) of zero, or of M
  function automatic logic even_near(input rns_t r);
    int x2;
    x2 = pair_merge(r[2], r[3], RN + 1);
    return (x2 & 1) == 0;
  endfunction

endpackage

// File: rtl/rns_pix_conv.sv
module rns_pix_conv
  import rns_sad_pkg::*;
(
  input  logic [PW-1:0] pix,
  output rns_t          res,
  output logic          odd
);
  assign res = to_rns(pix);
  assign odd = pix[0];
endmodule

// File: rtl/rns_abs_lane.sv
module rns_abs_lane
  import rns_sad_pkg::*;
(
  input  rns_t a,
  input  logic a_odd,
  input  rns_t b,
  input  logic b_odd,
  output rns_t mag
);
  rns_t fwd, bwd;
  logic ge;

  always_comb begin
    fwd = rns_sub(a, b);
    bwd = rns_sub(b, a);
    // odd count of even flags means a >= b
    ge  = (~a_odd) ^ (~b_odd) ^ even_near(fwd);
    mag = ge ? fwd : bwd;
  end
endmodule

// File: rtl/rns_sum_tree.sv
module rns_sum_tree
  import rns_sad_pkg::*;
#(
  parameter int LANES = 16
) (
  input  rns_t terms [LANES],
  output rns_t total
);
  rns_t node [1:2*LANES-1];

  for (genvar j = 0; j < LANES; j++) begin : g_leaf
    assign node[LANES + j] = terms[j];
  end
  for (genvar i = 1; i < LANES; i++) begin : g_node
    assign node[i] = rns_add(node[2*i], node[2*i + 1]);
  end

  assign total = node[1];
endmodule

// File: rtl/rns_min_track.sv
module rns_min_track
  import rns_sad_pkg::*;
#(
  parameter int MV_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            restart,
  input  rns_t            sad,
  input  logic [MV_W-1:0] su,
  input  logic [MV_W-1:0] sv,
  output logic            done,
  output rns_t            best,
  output logic            best_e,
  output logic [MV_W-1:0] bu,
  output logic [MV_W-1:0] bv,
  output logic            take
);
  rns_t base, gap;
  logic base_e, e_new, e_gap;

  always_comb begin
    base   = restart ? rns_top() : best;
    base_e = restart ? 1'b1 : best_e;
    gap    = rns_sub(sad, base);
    e_new  = even_full(sad);
    e_gap  = even_full(gap);
    // even XOR of the three flags: sad strictly below base
    take   = ~(e_new ^ base_e ^ e_gap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      best   <= rns_top();
      best_e <= 1'b1;
      bu     <= '0;
      bv     <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        if (take) begin
          best   <= sad;
          best_e <= e_new;
          bu     <= su;
          bv     <= sv;
        end else if (restart) begin
          best   <= rns_top();
          best_e <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rns_sad_min.sv
module rns_sad_min
  import rns_sad_pkg::*;
#(
  parameter int LANES = 16,
  parameter int ROWS  = 16,
  parameter int MV_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_vld,
  input  logic                row_first,
  input  logic                blk_first,
  input  logic [LANES*PW-1:0] cur_row,
  input  logic [LANES*PW-1:0] cand_row,
  input  logic [MV_W-1:0]     cand_u,
  input  logic [MV_W-1:0]     cand_v,
  output logic                done,
  output logic [NCH*RW-1:0]   best_res,
  output logic                best_even,
  output logic [MV_W-1:0]     best_u,
  output logic [MV_W-1:0]     best_v
);
  localparam int CW = $clog2(ROWS + 1);

  // conversion (combinational from the ports)
  rns_t cv_res [LANES];
  rns_t xv_res [LANES];
  logic [LANES-1:0] cv_odd, xv_odd;

  for (genvar c = 0; c < LANES; c++) begin : g_conv
    rns_pix_conv u_cur (.pix(cur_row[c*PW +: PW]),  .res(cv_res[c]), .odd(cv_odd[c]));
    rns_pix_conv u_cnd (.pix(cand_row[c*PW +: PW]), .res(xv_res[c]), .odd(xv_odd[c]));
  end

  // stage 1: residues of both rows
  logic            s1_vld, s1_first, s1_blk;
  logic [MV_W-1:0] s1_u, s1_v;
  rns_t            s1_cur [LANES];
  rns_t            s1_cnd [LANES];
  logic [LANES-1:0] s1_codd, s1_xodd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_blk   <= 1'b0;
      s1_u     <= '0;
      s1_v     <= '0;
      s1_cur   <= '{default: '0};
      s1_cnd   <= '{default: '0};
      s1_codd  <= '0;
      s1_xodd  <= '0;
    end else begin
      s1_vld   <= row_vld;
      s1_first <= row_first;
      s1_blk   <= blk_first;
      s1_u     <= cand_u;
      s1_v     <= cand_v;
      s1_cur   <= cv_res;
      s1_cnd   <= xv_res;
      s1_codd  <= cv_odd;
      s1_xodd  <= xv_odd;
    end
  end

  // stage 2: absolute differences
  rns_t ab_res [LANES];

  for (genvar c = 0; c < LANES; c++) begin : g_abs
    rns_abs_lane u_abs (
      .a(s1_cur[c]), .a_odd(s1_codd[c]),
      .b(s1_cnd[c]), .b_odd(s1_xodd[c]),
      .mag(ab_res[c])
    );
  end

  logic            s2_vld, s2_first, s2_blk;
  logic [MV_W-1:0] s2_u, s2_v;
  rns_t            s2_abs [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld   <= 1'b0;
      s2_first <= 1'b0;
      s2_blk   <= 1'b0;
      s2_u     <= '0;
      s2_v     <= '0;
      s2_abs   <= '{default: '0};
    end else begin
      s2_vld   <= s1_vld;
      s2_first <= s1_first;
      s2_blk   <= s1_blk;
      s2_u     <= s1_u;
      s2_v     <= s1_v;
      s2_abs   <= ab_res;
    end
  end

  // stage 3: per-channel row sum
  rns_t row_sum;

  rns_sum_tree #(.LANES(LANES)) u_tree (.terms(s2_abs), .total(row_sum));

  logic            s3_vld, s3_first, s3_blk;
  logic [MV_W-1:0] s3_u, s3_v;
  rns_t            s3_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_vld   <= 1'b0;
      s3_first <= 1'b0;
      s3_blk   <= 1'b0;
      s3_u     <= '0;
      s3_v     <= '0;
      s3_sum   <= '0;
    end else begin
      s3_vld   <= s2_vld;
      s3_first <= s2_first;
      s3_blk   <= s2_blk;
      s3_u     <= s2_u;
      s3_v     <= s2_v;
      s3_sum   <= row_sum;
    end
  end

  // stage 4: accumulate rows of one candidate
  rns_t            acc_q;
  logic [CW-1:0]   cnt_q, cnt_nxt;
  logic            fin_q, a_blk;
  logic [MV_W-1:0] a_u, a_v;

  assign cnt_nxt = s3_first ? CW'(1) : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
      a_blk <= 1'b0;
      a_u   <= '0;
      a_v   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (s3_vld) begin
        acc_q <= s3_first ? s3_sum : rns_add(acc_q, s3_sum);
        cnt_q <= cnt_nxt;
        fin_q <= (cnt_nxt == CW'(ROWS));
        if (s3_first) begin
          a_blk <= s3_blk;
          a_u   <= s3_u;
          a_v   <= s3_v;
        end
      end
    end
  end

  // stage 5: minimum tracking; events named for the checker
  logic cmp_fire, cmp_restart, cmp_take;
  rns_t best_q;

  assign cmp_fire    = fin_q;
  assign cmp_restart = a_blk;

  rns_min_track #(.MV_W(MV_W)) u_min (
    .clk(clk), .rst_n(rst_n),
    .fire(cmp_fire), .restart(cmp_restart),
    .sad(acc_q), .su(a_u), .sv(a_v),
    .done(done), .best(best_q), .best_e(best_even),
    .bu(best_u), .bv(best_v), .take(cmp_take)
  );

  assign best_res = best_q;
endmodule

// File: rtl/rns_sad_min_chk.sv
module rns_sad_min_chk
  import rns_sad_pkg::*;
#(
  parameter int MV_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [NCH*RW-1:0] best_res,
  input logic              best_even,
  input logic [MV_W-1:0]   best_u,
  input logic [MV_W-1:0]   best_v,
  input logic              cmp_fire,
  input logic              cmp_restart,
  input logic              cmp_take
);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> done);

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> !done);

  // R6
  restart_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && cmp_restart) |-> cmp_take);

  // R8
  best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(best_res) && $stable(best_even) && $stable(best_u) && $stable(best_v)));

  for (genvar k = 0; k < NCH; k++) begin : g_rng
    // R9
    res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(best_res[k*RW +: RW]) < modv(k));
  end
endmodule

bind rns_sad_min rns_sad_min_chk #(.MV_W(MV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .best_res(best_res),
  .best_even(best_even), .best_u(best_u), .best_v(best_v),
  .cmp_fire(cmp_fire), .cmp_restart(cmp_restart), .cmp_take(cmp_take)
);

// File: tb/rns_sad_min_bench.sv
`timescale 1ns/1ps
module rns_sad_min_bench;
  localparam int LANES = 16;
  localparam int ROWS  = 16;
  localparam int MV_W  = 6;
  localparam int MTOP  = 86955;
  localparam int NV    = 10;

  // stimulus table: current kind/seed, candidate kind/seed, u, v, new block, gapped rows
  localparam int T_CK  [NV] = '{0, 1,  0, 1,   1,   1, 0, 1,  1,  0};
  localparam int T_CS  [NV] = '{5, 200, 5, 200, 0, 255, 11, 10, 12, 20};
  localparam int T_XK  [NV] = '{0, 1,  0, 1,   1,   1, 0, 1,  1,  1};
  localparam int T_XS  [NV] = '{9, 200, 9, 200, 255, 0, 3, 12, 10, 128};
  localparam int T_U   [NV] = '{1, 3, 5, 7, 9, 10, 11, 2, 4, 6};
  localparam int T_V   [NV] = '{2, 4, 6, 7, 1, 2, 3, 5, 4, 8};
  localparam int T_BLK [NV] = '{1, 0, 0, 0, 1, 0, 0, 1, 0, 0};
  localparam int T_GAP [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n;
  logic row_vld, row_first, blk_first;
  logic [LANES*8-1:0] cur_row, cand_row;
  logic [MV_W-1:0] cand_u, cand_v;
  logic done, best_even;
  logic [23:0] best_res;
  logic [MV_W-1:0] best_u, best_v;

  int tests = 0;
  int fails = 0;
  int bm, bu, bv;
  bit pend = 0;
  int pcnt = 0;
  string ereq;

  always #2 clk = ~clk;

  rns_sad_min #(.LANES(LANES), .ROWS(ROWS), .MV_W(MV_W)) u_rns_sad_min (
    .clk(clk), .rst_n(rst_n), .row_vld(row_vld), .row_first(row_first),
    .blk_first(blk_first), .cur_row(cur_row), .cand_row(cand_row),
    .cand_u(cand_u), .cand_v(cand_v), .done(done), .best_res(best_res),
    .best_even(best_even), .best_u(best_u), .best_v(best_v)
  );

  function automatic string req_of(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R5";
      4: return "R6";
      5: return "R4";
      6: return "R3";
      7: return "R6";
      8: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic int pixv(input int kind, input int seed, input int r, input int c);
    if (kind == 1) return seed & 255;
    return (seed * 37 + r * 13 + c * 7 + r * c * 3) & 255;
  endfunction

  function automatic int res_of(input int x);
    int m [4] = '{15, 17, 31, 33};
    int v = 0;
    for (int k = 0; k < 4; k++) v |= (x % m[k]) << (6 * k);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_init(input string what);
    // R1
    check(done == 1'b0, "R1", {what, " done"}, int'(done), 0);
    check(int'(best_res) == res_of(MTOP - 1), "R1", {what, " best_res"}, int'(best_res), res_of(MTOP - 1));
    check(best_even == 1'b1, "R1", {what, " best_even"}, int'(best_even), 1);
    check(best_u == '0 && best_v == '0, "R1", {what, " vector"}, int'({best_u, best_v}), 0);
  endtask

  task automatic step();
    @(negedge clk);
    if (pend) begin
      pcnt++;
      if (pcnt == 5) begin
        pend = 0;
        check(done == 1'b1, "R2", "done at latency", int'(done), 1);
        check(int'(best_res) == res_of(bm), ereq, "best_res", int'(best_res), res_of(bm));
        check(best_even == ((bm % 2) == 0), "R7", "best_even", int'(best_even), int'((bm % 2) == 0));
        check(int'(best_u) == bu && int'(best_v) == bv, "R10", "vector", int'({best_u, best_v}), (bu << MV_W) | bv);
        // R9
        check(best_res[5:0] < 15 && best_res[11:6] < 17 && best_res[17:12] < 31 && best_res[23:18] < 33,
              "R9", "channel range", int'(best_res), res_of(bm));
      end else if (done) begin
        check(1'b0, "R2", "early done", 1, 0);
      end
    end else if (done) begin
      check(1'b0, "R2", "spurious done", 1, 0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      row_vld = 1'b0;
      row_first = 1'b0;
    end
  endtask

  task automatic drive_cand(input int kc, input int sc, input int kx, input int sx,
                            input int u, input int v, input int blk, input int gap, input string req);
    int sad = 0;
    for (int r = 0; r < ROWS; r++) begin
      if (gap != 0 && r > 0) begin
        step();
        row_vld = 1'b0;
        row_first = 1'b0;
      end
      step();
      row_vld   = 1'b1;
      row_first = (r == 0);
      blk_first = (blk != 0);
      // R10: the vector is only meaningful on the first row
      cand_u = (r == 0) ? MV_W'(u) : ~MV_W'(u);
      cand_v = (r == 0) ? MV_W'(v) : ~MV_W'(v);
      for (int c = 0; c < LANES; c++) begin
        int a, b;
        a = pixv(kc, sc, r, c);
        b = pixv(kx, sx, r, c);
        cur_row[c*8 +: 8]  = 8'(a);
        cand_row[c*8 +: 8] = 8'(b);
        sad += (a > b) ? a - b : b - a;
      end
    end
    if (blk != 0) bm = MTOP - 1;
    if (sad < bm) begin
      bm = sad;
      bu = u;
      bv = v;
    end
    ereq = req;
    pend = 1;
    pcnt = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    row_vld = 1'b0;
    row_first = 1'b0;
    blk_first = 1'b0;
    cur_row = '0;
    cand_row = '0;
    cand_u = '0;
    cand_v = '0;
    bm = MTOP - 1;
    bu = 0;
    bv = 0;
    repeat (3) @(negedge clk);
    chk_init("in reset");
    rst_n = 1'b1;
    idle(2);
    chk_init("after reset");

    for (int i = 0; i < NV; i++) begin
      drive_cand(T_CK[i], T_CS[i], T_XK[i], T_XS[i], T_U[i], T_V[i], T_BLK[i], T_GAP[i], req_of(i));
    end
    idle(8);
    // R8: outputs hold while idle
    check(int'(best_res) == res_of(bm), "R8", "held best", int'(best_res), res_of(bm));

    // reset in the middle of a pending candidate
    drive_cand(1, 50, 1, 60, 13, 14, 0, 0, "R5");
    idle(2);
    rst_n = 1'b0;
    pend = 0;
    bm = MTOP - 1;
    bu = 0;
    bv = 0;
    step();
    chk_init("mid-run reset");
    rst_n = 1'b1;
    idle(2);
    // R1: without a new-block mark the first candidate is measured against M-1
    drive_cand(1, 100, 1, 90, 21, 22, 0, 1, "R1");
    idle(8);
    check(int'(best_res) == res_of(bm), "R8", "held after run", int'(best_res), res_of(bm));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule